// File: doc/BRIEF.md
# AES-256 Stepped Round Encryption Datapath

This block encrypts one 128-bit block under AES-256 given an already expanded set of fifteen 128-bit round keys. A small state machine walks the block register through one transformation per clock cycle: byte substitution, row rotation, column mixing and key addition. Each transformation has its own registered enable, and a 4-bit round index selects the round key.

A request is taken when `start` and `keys_ready` are both high and the engine is not busy. The plaintext is captured on that edge and `done` drops. The engine first adds round key 0. It then runs thirteen full rounds and a final round that skips column mixing. After that it raises `done` and holds the ciphertext until the next accepted request. The key schedule is computed elsewhere, and the result is read as one parallel word.

Top module: `aes_round_engine`

## Requirements
- R1: After synchronous reset, `done` is 0 and `ciphertext` is all zeros.
- R2: A `start` pulse while `keys_ready` is low is ignored. `done` and `ciphertext` keep their values.
- R3: `done` is low for the first 4*NUM_ROUNDS-1 rising edges after the accepting edge. It is high after edge 4*NUM_ROUNDS, which is edge 56 for fourteen rounds.
- R4: `ciphertext` equals the AES-256 encryption of the captured plaintext. Byte 0 of a block sits in bits 127:120, and bytes fill the state column by column. Round key i sits in `round_keys[128*i+127 : 128*i]`. Key 0 is added first, rounds 1 to 13 are full, and round 14 omits column mixing. For key 000102..1f and plaintext 00112233..eeff the result is 8ea2b7ca516745bfeafc49904b496089.
- R5: `done` is low after the edge that accepts a request. This includes a request taken while a previous result is shown.
- R6: A `start` while an encryption is running is ignored. The result and the latency belong to the request already accepted.
- R7: While `done` is high and no request is accepted, `done` and `ciphertext` stay constant, whatever `plaintext` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| keys_ready | input | 1 | Round keys on `round_keys` are valid |
| start | input | 1 | Encryption request |
| plaintext | input | 128 | Block captured on the accepting edge |
| round_keys | input | 128*(NUM_ROUNDS+1) | Expanded keys, key i in slice i |
| done | output | 1 | Result valid |
| ciphertext | output | 128 | Block register; valid while `done` is high |

## Verification
The accepting rising edge is counted as edge 0. The block register loads the plaintext on that edge, so `done` must already be low at the falling edge that follows it. The bench drives every input on falling edges and also samples on falling edges. Once a request is accepted, it counts falling edges: `done` must still be low after edge 55 and must be high, with the expected ciphertext, after edge 56. Requests that should be ignored are held for several cycles, and `done` and `ciphertext` are then compared with their earlier values at the next falling edge.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

    localparam int BLK_W  = 128;
    localparam int BYTE_W = 8;
    localparam int NBYTES = BLK_W / BYTE_W;
    localparam int ROWS   = 4;
    localparam int COLS   = NBYTES / ROWS;
    localparam int LUT_N  = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0]             byte_t;
    typedef logic [NBYTES-1:0][BYTE_W-1:0] block_t;
    typedef logic [LUT_N-1:0][BYTE_W-1:0]  lut_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARK   = 3'd1,
        ST_SUB   = 3'd2,
        ST_SHIFT = 3'd3,
        ST_MIX   = 3'd4,
        ST_DONE  = 3'd5
    } step_state_e;

    typedef struct packed {
        logic sub;
        logic shift;
        logic mix;
        logic ark;
    } step_en_t;

    // Packed element holding the k-th byte of the block (byte 0 = MSBs).
    function automatic int byte_pos(int k);
        return NBYTES - 1 - k;
    endfunction

    // Row rotation: output byte k takes the byte of the same row,
    // (column + row) mod COLS.
    function automatic int shift_src(int k);
        return (k % ROWS) + ROWS * (((k / ROWS) + (k % ROWS)) % COLS);
    endfunction

    function automatic byte_t gf_dbl(byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    // Walks the multiplicative group with generator 3 and its inverse
    // in lockstep, applying the affine map to the inverse.
    function automatic lut_t build_sbox();
        lut_t  t;
        byte_t p;
        byte_t q;
        t = '0;
        p = 8'h01;
        q = 8'h01;
        t[0] = 8'h63;
        for (int i = 0; i < LUT_N - 1; i++) begin
            p = p ^ gf_dbl(p);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            t[p] = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]}
                     ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
        end
        return t;
    endfunction

    function automatic lut_t build_mul2();
        lut_t t;
        for (int i = 0; i < LUT_N; i++) t[i] = gf_dbl(byte_t'(i));
        return t;
    endfunction

    function automatic lut_t build_mul3();
        lut_t t;
        for (int i = 0; i < LUT_N; i++) t[i] = gf_dbl(byte_t'(i)) ^ byte_t'(i);
        return t;
    endfunction

    function automatic step_en_t enables_for(step_state_e s);
        step_en_t e;
        e       = '0;
        e.ark   = (s == ST_ARK);
        e.sub   = (s == ST_SUB);
        e.shift = (s == ST_SHIFT);
        e.mix   = (s == ST_MIX);
        return e;
    endfunction

endpackage

// File: rtl/aes_sub_bytes.sv
module aes_sub_bytes
    import aes_seq_pkg::*;
(
    input  block_t din,
    output block_t dout
);
    localparam lut_t SBOX_TBL = build_sbox();

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign dout[g] = SBOX_TBL[din[g]];
    end
endmodule

// File: rtl/aes_shift_rows.sv
module aes_shift_rows
    import aes_seq_pkg::*;
(
    input  block_t din,
    output block_t dout
);
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam int DST = byte_pos(k);
        localparam int SRC = byte_pos(shift_src(k));
        assign dout[DST] = din[SRC];
    end
endmodule

// File: rtl/aes_mix_columns.sv
module aes_mix_columns
    import aes_seq_pkg::*;
(
    input  block_t din,
    output block_t dout
);
    localparam lut_t MUL2_TBL = build_mul2();
    localparam lut_t MUL3_TBL = build_mul3();

    // Row r of a column: 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3] (mod 4).
    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int P0 = byte_pos(ROWS * c + r);
            localparam int P1 = byte_pos(ROWS * c + (r + 1) % ROWS);
            localparam int P2 = byte_pos(ROWS * c + (r + 2) % ROWS);
            localparam int P3 = byte_pos(ROWS * c + (r + 3) % ROWS);
            assign dout[P0] = MUL2_TBL[din[P0]] ^ MUL3_TBL[din[P1]]
                            ^ din[P2] ^ din[P3];
        end
    end
endmodule

// File: rtl/aes_step_fsm.sv
module aes_step_fsm
    import aes_seq_pkg::*;
#(
    parameter int NUM_ROUNDS = 14,
    parameter int RW         = $clog2(NUM_ROUNDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          keys_ready,
    output step_en_t      step_en,
    output logic [RW-1:0] round_idx,
    output logic          accept,
    output logic          busy,
    output logic          done
);
    localparam logic [RW-1:0] LAST = RW'(NUM_ROUNDS);

    step_state_e   state_q, state_d;
    logic [RW-1:0] round_q, round_d;
    step_en_t      en_q;

    assign accept = start && keys_ready &&
                    (state_q == ST_IDLE || state_q == ST_DONE);

    always_comb begin
        state_d = state_q;
        round_d = round_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    state_d = ST_ARK;
                    round_d = '0;
                end
            end
            ST_ARK: begin
                if (round_q == LAST) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_SUB;
                    round_d = round_q + RW'(1);
                end
            end
            ST_SUB:   state_d = ST_SHIFT;
            ST_SHIFT: state_d = (round_q == LAST) ? ST_ARK : ST_MIX;
            ST_MIX:   state_d = ST_ARK;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            round_q <= '0;
            en_q    <= '0;
        end else begin
            state_q <= state_d;
            round_q <= round_d;
            en_q    <= enables_for(state_d);
        end
    end

    assign step_en   = en_q;
    assign round_idx = round_q;
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine
    import aes_seq_pkg::*;
#(
    parameter int NUM_ROUNDS = 14,
    parameter int KEYS_W     = (NUM_ROUNDS + 1) * 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              keys_ready,
    input  logic              start,
    input  logic [127:0]      plaintext,
    input  logic [KEYS_W-1:0] round_keys,
    output logic              done,
    output logic [127:0]      ciphertext
);
    localparam int RW = $clog2(NUM_ROUNDS + 1);

    step_en_t      step_en;
    logic [RW-1:0] round_idx;
    logic          accept;
    logic          busy;
    block_t        blk_q;
    block_t        sub_o, shf_o, mix_o;
    logic [BLK_W-1:0] rkey;

    aes_step_fsm #(.NUM_ROUNDS(NUM_ROUNDS), .RW(RW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .keys_ready (keys_ready),
        .step_en    (step_en),
        .round_idx  (round_idx),
        .accept     (accept),
        .busy       (busy),
        .done       (done)
    );

    aes_sub_bytes   u_sub (.din(blk_q), .dout(sub_o));
    aes_shift_rows  u_shf (.din(blk_q), .dout(shf_o));
    aes_mix_columns u_mix (.din(blk_q), .dout(mix_o));

    assign rkey = round_keys[int'(round_idx) * BLK_W +: BLK_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= '0;
        end else if (accept) begin
            blk_q <= plaintext;
        end else if (step_en.ark) begin
            blk_q <= blk_q ^ rkey;
        end else if (step_en.sub) begin
            blk_q <= sub_o;
        end else if (step_en.shift) begin
            blk_q <= shf_o;
        end else if (step_en.mix) begin
            blk_q <= mix_o;
        end
    end

    assign ciphertext = blk_q;
endmodule

// File: rtl/aes_round_engine_chk.sv
module aes_round_engine_chk #(
    parameter int NR = 14
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         keys_ready,
    input logic         busy,
    input logic         done,
    input logic [127:0] ciphertext,
    input logic [3:0]   step_en
);
    localparam int LAT = 4 * NR;
    localparam int CW  = $clog2(LAT + 2);

    logic          took;
    logic [CW-1:0] cnt;

    assign took = start && keys_ready && !busy;

    always_ff @(posedge clk) begin
        if (rst)                            cnt <= '0;
        else if (took)                      cnt <= '0;
        else if (busy && cnt != CW'(LAT+1)) cnt <= cnt + CW'(1);
    end

    a_r2_ignore_unready: assert property (@(posedge clk) disable iff (rst)
        (!busy && !keys_ready) |=> ($stable(done) && $stable(ciphertext)));

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cnt == CW'(LAT)));

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_en));

    a_r5_done_falls: assert property (@(posedge clk) disable iff (rst)
        took |=> !done);

    a_r6_busy_continues: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && keys_ready)) |=> (done && $stable(ciphertext)));
endmodule

bind aes_round_engine aes_round_engine_chk #(.NR(NUM_ROUNDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .keys_ready (keys_ready),
    .busy       (busy),
    .done       (done),
    .ciphertext (ciphertext),
    .step_en    (step_en)
);

// File: tb/sim_aes_round_engine.sv
`timescale 1ns/1ps
module sim_aes_round_engine;
    localparam int NR  = 14;
    localparam int LAT = 4 * NR;
    localparam int KW  = (NR + 1) * 128;

    logic          clk = 1'b0;
    logic          rst;
    logic          keys_ready;
    logic          start;
    logic [127:0]  plaintext;
    logic [KW-1:0] round_keys;
    logic          done;
    logic [127:0]  ciphertext;

    always #5 clk = ~clk;

    aes_round_engine #(.NUM_ROUNDS(NR)) u0 (
        .clk(clk), .rst(rst), .keys_ready(keys_ready), .start(start),
        .plaintext(plaintext), .round_keys(round_keys),
        .done(done), .ciphertext(ciphertext)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] sb [256];

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    function automatic logic [7:0] xt(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = xt(x);
        end
        return r;
    endfunction

    // S-box from the field inverse (b^254) and the affine map.
    task automatic make_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = 8'h01;
            logic [7:0] b   = 8'(v);
            logic [7:0] s;
            for (int e = 0; e < 254; e++) inv = gmul(inv, b);
            if (v == 0) inv = 8'h00;
            s = inv;
            for (int k = 1; k <= 4; k++) s = s ^ ((inv << k) | (inv >> (8 - k)));
            sb[v] = s ^ 8'h63;
        end
    endtask

    function automatic logic [KW-1:0] expand_key(input logic [255:0] key);
        logic [31:0]   w [60];
        logic [31:0]   tmp;
        logic [7:0]    rc = 8'h01;
        logic [KW-1:0] rk = '0;
        for (int i = 0; i < 8; i++) w[i] = key[255 - 32*i -: 32];
        for (int i = 8; i < 60; i++) begin
            tmp = w[i-1];
            if (i % 8 == 0) begin
                tmp = {tmp[23:0], tmp[31:24]};
                tmp = {sb[tmp[31:24]], sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]]};
                tmp[31:24] = tmp[31:24] ^ rc;
                rc = xt(rc);
            end else if (i % 8 == 4) begin
                tmp = {sb[tmp[31:24]], sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]]};
            end
            w[i] = w[i-8] ^ tmp;
        end
        for (int r = 0; r <= NR; r++)
            rk[r*128 +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
        return rk;
    endfunction

    function automatic logic [127:0] ref_encrypt(input logic [KW-1:0] rk,
                                                 input logic [127:0] pt);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] a0, a1, a2, a3;
        logic [127:0] res;
        for (int k = 0; k < 16; k++) s[k] = pt[127-8*k -: 8] ^ rk[127-8*k -: 8];
        for (int r = 1; r <= NR; r++) begin
            for (int k = 0; k < 16; k++) t[k] = sb[s[k]];
            for (int k = 0; k < 16; k++) s[k] = t[(k%4) + 4*(((k/4) + (k%4)) % 4)];
            if (r != NR) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    s[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end
            end
            for (int k = 0; k < 16; k++) s[k] = s[k] ^ rk[r*128 + 127 - 8*k -: 8];
        end
        for (int k = 0; k < 16; k++) res[127-8*k -: 8] = s[k];
        return res;
    endfunction

    function automatic logic [63:0] xs(input logic [63:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // One accepted request; optional start pulses while busy (R6).
    task automatic run_block(input logic [255:0] key, input logic [127:0] pt,
                             input bit meddle);
        logic [KW-1:0]  rk;
        logic [127:0]   exp_ct;
        rk     = expand_key(key);
        exp_ct = ref_encrypt(rk, pt);
        @(negedge clk);
        round_keys = rk;
        plaintext  = pt;
        keys_ready = 1'b1;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R5 done low after accept", 128'(done), 128'd0);
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            if (meddle && i == 10) begin start = 1'b1; plaintext = ~pt; end
            if (meddle && i == 13) start = 1'b0;
        end
        check(done == 1'b0, meddle ? "R6 R3 done early" : "R3 done early",
              128'(done), 128'd0);
        @(negedge clk);
        check(done == 1'b1, meddle ? "R6 R3 done late" : "R3 done late",
              128'(done), 128'd1);
        check(ciphertext == exp_ct, meddle ? "R6 R4 result" : "R4 result",
              ciphertext, exp_ct);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] fips_key;
        logic [127:0] fips_pt;
        logic [127:0] held;
        logic [63:0]  seed;
        fips_key = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
        fips_pt  = 128'h00112233445566778899aabbccddeeff;
        make_sbox();

        rst = 1'b1; keys_ready = 1'b0; start = 1'b0;
        plaintext = '0; round_keys = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", 128'(done), 128'd0);
        check(ciphertext == '0, "R1 ciphertext after reset", ciphertext, 128'd0);

        // R2: request without ready keys from idle
        plaintext  = fips_pt;
        round_keys = expand_key(fips_key);
        start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R2 idle done", 128'(done), 128'd0);
        check(ciphertext == '0, "R2 idle ciphertext", ciphertext, 128'd0);

        // R4: published vector
        run_block(fips_key, fips_pt, 1'b0);
        check(ciphertext == 128'h8ea2b7ca516745bfeafc49904b496089, "R4 FIPS vector",
              ciphertext, 128'h8ea2b7ca516745bfeafc49904b496089);

        // R7: result held while plaintext moves
        held = ciphertext;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            plaintext = {4{32'(i * 32'h9e3779b9)}};
        end
        @(negedge clk);
        check(done == 1'b1, "R7 done held", 128'(done), 128'd1);
        check(ciphertext == held, "R7 ciphertext held", ciphertext, held);

        // R2: request without ready keys while showing a result
        keys_ready = 1'b0;
        start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b1, "R2 done kept", 128'(done), 128'd1);
        check(ciphertext == held, "R2 ciphertext kept", ciphertext, held);

        // Sweep: corner keys and pseudo-random vectors, back to back (R5),
        // every second one with start pulses while busy (R6).
        run_block('0, '0, 1'b0);
        run_block('1, '1, 1'b1);
        seed = 64'h0123_4567_89ab_cdef;
        for (int v = 0; v < 10; v++) begin
            logic [255:0] k;
            logic [127:0] p;
            for (int j = 0; j < 4; j++) begin seed = xs(seed); k[64*j +: 64] = seed; end
            for (int j = 0; j < 2; j++) begin seed = xs(seed); p[64*j +: 64] = seed; end
            run_block(k, p, v[0]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule